// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is a private, direct-mapped, write-through cache that sits between one processor and a shared bus. It serves processor byte reads from its line store when the line is present. It sends every processor write through to main memory with a bus write transaction. When a read misses, it fetches the whole line over the bus. Each line carries one valid bit and nothing more, because memory always holds the current copy. It can therefore drop any line at any time without writing anything back.

Other caches on the bus announce their writes on a snoop port. If such a write hits a line held here, that line is invalidated. Writes that this cache made itself are echoed on the same port and are recognised by an identifier, so they do not disturb its own lines. The tag directory has two lookup paths, one for the processor and one for the snoop port, and both are served in the same cycle. A static mode input chooses how a write miss is handled. In the first mode the write goes to memory only. In the second mode the line is fetched first, the byte is merged into it, and the line is kept.

The bus side is a request/grant handshake. The cache raises a request with the command, address and write byte, and holds them until grant. The read line is taken from the bus in the grant cycle. Arbitration and memory belong to the surrounding system.

Top module: `snoop_wt_cache`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, every line is invalid, `bus_req` and `cpu_done` are low and `cpu_ready` is high.
- R2: A read that hits completes with `cpu_done` one cycle after acceptance, returns the stored byte and raises no bus request.
- R3: A read that misses raises `bus_req` with `bus_cmd`=0 (line read) for the address. In the grant cycle the line is taken from `bus_rdata` (byte k in bits 8k+7..8k), marked valid with tag addr[9:6] at index addr[5:3], and the byte at offset addr[2:0] is returned with `cpu_done`.
- R4: Every processor write, hit or miss, produces exactly one bus transaction with `bus_cmd`=1 carrying the write address and byte. `cpu_done` follows in its grant cycle.
- R5: A write hit also updates the stored byte, so a later read hit returns the written value.
- R6: With `wr_alloc`=0, a write miss issues no line read and allocates nothing, so the next read of that line misses.
- R7: With `wr_alloc`=1, a write miss first reads the line, merges the byte and marks the line valid, and only then issues the bus write. A later read of the line hits.
- R8: A snooped write whose `snp_id` differs from the cache's own identifier, and whose address matches a valid line in both index and tag, invalidates that line. A snoop with the same index but a different tag changes nothing.
- R9: A snooped write carrying the cache's own identifier never invalidates a line.
- R10: If a snoop invalidation and a processor access fall on the same line in the same cycle, the invalidation wins and the access is handled as a miss.
- R11: While `bus_req` is high and grant is absent, `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` stay unchanged.
- R12: `cpu_done` is a single-cycle pulse, and `cpu_ready` is low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_alloc | input | 1 | Write-miss policy: 0 write memory only, 1 fetch then merge |
| cpu_req | input | 1 | Processor access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 10 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_done | output | 1 | Access finished (single-cycle pulse) |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` after a read |
| bus_req | output | 1 | Bus request, held until grant |
| bus_gnt | input | 1 | Bus grant; the transaction completes in this cycle |
| bus_cmd | output | 1 | 0 line read, 1 byte write |
| bus_addr | output | 10 | Transaction byte address |
| bus_wdata | output | 8 | Byte to write to memory |
| bus_rdata | input | 64 | Line returned by memory in the grant cycle |
| snp_wr | input | 1 | A bus write is being observed |
| snp_addr | input | 10 | Address of the observed write |
| snp_id | input | 2 | Identifier of the cache that issued the observed write |

## Verification
On every cycle, the assertions check the rules that can be seen at a single line or port. A foreign snoop hit must clear the line, and an echo of the cache's own write must leave it alone. A same-cycle conflict must not complete the processor access as a hit. The bus request must be held steady until grant. The done pulse must last one cycle, and the reset state must be correct. Other properties can only be shown by the scenarios: every read returning the memory value, the count of line reads and byte writes per access under each write-miss mode, and whether a line stays present after writes or snoops. For these, the bench keeps its own memory image and line directory and compares each access against them.

// File: rtl/swc_pkg.sv
// Shared types for the write-through snooping cache.
// Assumes: a single outstanding processor access at a time.
package swc_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,   // waiting for a processor request
        ST_RD_FILL  = 2'd1,   // read miss, waiting for line data
        ST_WR_FETCH = 2'd2,   // allocating write miss, fetching the line
        ST_WR_BUS   = 2'd3    // write going through to memory
    } swc_state_t;

    // Bus command encoding
    localparam logic CMD_LINE_RD = 1'b0;
    localparam logic CMD_BYTE_WR = 1'b1;

endpackage

// File: rtl/swc_dir.sv
// Tag and valid directory with two independent lookup paths.
// The processor path reports a hit; the snoop path reports a kill, which
// clears the line at the next edge and masks a processor hit on the same
// index in the same cycle. A fill and a kill on one line: the kill wins.
// Assumes: snp_en is already filtered to writes from other caches.
module swc_dir #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         cpu_idx,
    input  logic [TAG_W-1:0]         cpu_tag,
    input  logic                     snp_en,
    input  logic [IDX_W-1:0]         snp_idx,
    input  logic [TAG_W-1:0]         snp_tag,
    input  logic                     fill_en,
    input  logic [IDX_W-1:0]         fill_idx,
    input  logic [TAG_W-1:0]         fill_tag,
    output logic                     cpu_hit,
    output logic                     snp_kill,
    output logic [LINES-1:0]         valid_o,
    output logic [LINES*TAG_W-1:0]   tags_o
);

    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_entry
        logic             v_q;
        logic [TAG_W-1:0] t_q;

        // Per-line state: fill sets, a snoop kill clears last
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else begin
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    v_q <= 1'b1;
                    t_q <= fill_tag;
                end
                if (snp_kill && snp_idx == IDX_W'(i)) begin
                    v_q <= 1'b0;
                end
            end
        end

        assign valid_o[i]                  = v_q;
        assign tag_arr[i]                  = t_q;
        assign tags_o[i*TAG_W +: TAG_W]    = t_q;
    end

    // Snoop lookup path
    always_comb begin
        snp_kill = snp_en && valid_o[snp_idx] && (tag_arr[snp_idx] == snp_tag);
    end

    // Processor lookup path, masked by a same-line kill
    always_comb begin
        cpu_hit = valid_o[cpu_idx] && (tag_arr[cpu_idx] == cpu_tag)
                  && !(snp_kill && (snp_idx == cpu_idx));
    end

endmodule

// File: rtl/swc_data.sv
// Line storage: one combinational byte read port, one byte write port for
// write hits and one whole-line write port for fills, with an optional
// byte merge into the incoming line (allocating write miss).
// Assumes: byte and line writes never occur in the same cycle. No reset;
// contents are meaningful only where the directory marks a line valid.
module swc_data #(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int IDX_W      = 3,
    parameter int OFF_W      = 3,
    parameter int LINE_W     = 64
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [7:0]        rd_byte,
    input  logic              byte_we,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [7:0]        byte_din,
    input  logic              line_we,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [LINE_W-1:0] line_din,
    input  logic              merge_en,
    input  logic [OFF_W-1:0]  merge_off,
    input  logic [7:0]        merge_din
);

    logic [LINE_W-1:0] line_arr [LINES];
    logic [LINE_W-1:0] fill_line;

    // Build the line to store: bus data with the write byte optionally merged
    always_comb begin
        fill_line = line_din;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (merge_en && merge_off == OFF_W'(b)) begin
                fill_line[b*8 +: 8] = merge_din;
            end
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [LINE_W-1:0] l_q;

        // Line store update: whole-line fill or single-byte write
        always_ff @(posedge clk) begin
            if (line_we && line_idx == IDX_W'(i)) begin
                l_q <= fill_line;
            end else if (byte_we && byte_idx == IDX_W'(i)) begin
                l_q[{byte_off, 3'b000} +: 8] <= byte_din;
            end
        end

        assign line_arr[i] = l_q;
    end

    // Combinational byte read for processor hits
    always_comb begin
        rd_byte = line_arr[rd_idx][{rd_off, 3'b000} +: 8];
    end

endmodule

// File: rtl/swc_ctrl.sv
// Access sequencer. It accepts one processor request at a time, decides
// hit or miss from the directory, and runs the bus request/grant handshake
// for line reads and write-through byte writes.
// Assumes: memory completes a granted transaction in the grant cycle, and
// wr_alloc changes only while idle.
module swc_ctrl
    import swc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 3,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_alloc,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_hit,
    input  logic [7:0]        hit_byte,
    input  logic              bus_gnt,
    input  logic [LINE_W-1:0] bus_rdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [7:0]        cpu_rdata,
    output logic              bus_req,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              byte_we,
    output logic              fill_we,
    output logic              fill_merge,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata
);

    swc_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              done_q;
    logic [7:0]        rdata_q;
    logic              accept;

    // Request acceptance
    always_comb begin
        accept = cpu_req && cpu_ready;
    end

    // Sequencer state, request latch and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                        if (cpu_we) begin
                            state_q <= (cpu_hit || !wr_alloc) ? ST_WR_BUS : ST_WR_FETCH;
                        end else if (cpu_hit) begin
                            done_q  <= 1'b1;
                            rdata_q <= hit_byte;
                        end else begin
                            state_q <= ST_RD_FILL;
                        end
                    end
                end
                ST_RD_FILL: begin
                    if (bus_gnt) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        rdata_q <= bus_rdata[{addr_q[OFF_W-1:0], 3'b000} +: 8];
                    end
                end
                ST_WR_FETCH: begin
                    if (bus_gnt) begin
                        state_q <= ST_WR_BUS;
                    end
                end
                ST_WR_BUS: begin
                    if (bus_gnt) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus-side outputs, held from the latched request
    always_comb begin
        bus_req   = (state_q != ST_IDLE);
        bus_cmd   = (state_q == ST_WR_BUS) ? CMD_BYTE_WR : CMD_LINE_RD;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
    end

    // Array and directory strobes
    always_comb begin
        byte_we    = accept && cpu_we && cpu_hit;
        fill_we    = bus_gnt && (state_q == ST_RD_FILL || state_q == ST_WR_FETCH);
        fill_merge = (state_q == ST_WR_FETCH);
    end

    // Processor-side outputs
    always_comb begin
        cpu_ready = (state_q == ST_IDLE) && !done_q;
        cpu_done  = done_q;
        cpu_rdata = rdata_q;
        req_addr  = addr_q;
        req_wdata = wdata_q;
    end

endmodule

// File: rtl/snoop_wt_cache.sv
// Top of the write-through snooping cache. It splits addresses into
// tag/index/offset, filters out snoops that carry this cache's own
// identifier, and connects the directory, the line store and the sequencer.
// Assumes: snoops describe completed writes by other bus masters.
module snoop_wt_cache
    import swc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int ID_W       = 2,
    parameter int CACHE_ID   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_alloc,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [7:0]              cpu_rdata,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [7:0]              bus_wdata,
    input  logic [8*LINE_BYTES-1:0] bus_rdata,
    input  logic                    snp_wr,
    input  logic [ADDR_W-1:0]       snp_addr,
    input  logic [ID_W-1:0]         snp_id
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = 8 * LINE_BYTES;

    logic                   cpu_hit;
    logic                   snp_kill;
    logic                   snp_foreign;
    logic [LINES-1:0]       dir_valid;
    logic [LINES*TAG_W-1:0] dir_tags;
    logic [7:0]             hit_byte;
    logic                   byte_we;
    logic                   fill_we;
    logic                   fill_merge;
    logic [ADDR_W-1:0]      req_addr;
    logic [7:0]             req_wdata;

    // Snoop filter: ignore echoes of this cache's own bus writes
    always_comb begin
        snp_foreign = snp_wr && (snp_id != ID_W'(CACHE_ID));
    end

    swc_dir #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_idx  (cpu_addr[OFF_W +: IDX_W]),
        .cpu_tag  (cpu_addr[ADDR_W-1 -: TAG_W]),
        .snp_en   (snp_foreign),
        .snp_idx  (snp_addr[OFF_W +: IDX_W]),
        .snp_tag  (snp_addr[ADDR_W-1 -: TAG_W]),
        .fill_en  (fill_we),
        .fill_idx (req_addr[OFF_W +: IDX_W]),
        .fill_tag (req_addr[ADDR_W-1 -: TAG_W]),
        .cpu_hit  (cpu_hit),
        .snp_kill (snp_kill),
        .valid_o  (dir_valid),
        .tags_o   (dir_tags)
    );

    swc_data #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES),
        .IDX_W      (IDX_W),
        .OFF_W      (OFF_W),
        .LINE_W     (LINE_W)
    ) u_data (
        .clk       (clk),
        .rd_idx    (cpu_addr[OFF_W +: IDX_W]),
        .rd_off    (cpu_addr[OFF_W-1:0]),
        .rd_byte   (hit_byte),
        .byte_we   (byte_we),
        .byte_idx  (cpu_addr[OFF_W +: IDX_W]),
        .byte_off  (cpu_addr[OFF_W-1:0]),
        .byte_din  (cpu_wdata),
        .line_we   (fill_we),
        .line_idx  (req_addr[OFF_W +: IDX_W]),
        .line_din  (bus_rdata),
        .merge_en  (fill_merge),
        .merge_off (req_addr[OFF_W-1:0]),
        .merge_din (req_wdata)
    );

    swc_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LINE_W (LINE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_alloc   (wr_alloc),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_hit    (cpu_hit),
        .hit_byte   (hit_byte),
        .bus_gnt    (bus_gnt),
        .bus_rdata  (bus_rdata),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .bus_req    (bus_req),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .byte_we    (byte_we),
        .fill_we    (fill_we),
        .fill_merge (fill_merge),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata)
    );

endmodule

// File: rtl/snoop_wt_cache_chk.sv
// Property checker for snoop_wt_cache, attached by bind below.
// It observes the ports plus the directory valid and tag vectors.
module snoop_wt_cache_chk #(
    parameter int ADDR_W   = 10,
    parameter int LINES    = 8,
    parameter int IDX_W    = 3,
    parameter int TAG_W    = 4,
    parameter int OFF_W    = 3,
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req,
    input logic                   cpu_ready,
    input logic                   cpu_done,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   bus_req,
    input logic                   bus_gnt,
    input logic                   bus_cmd,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [7:0]             bus_wdata,
    input logic                   snp_wr,
    input logic [ADDR_W-1:0]      snp_addr,
    input logic [ID_W-1:0]        snp_id,
    input logic [LINES-1:0]       dir_valid,
    input logic [LINES*TAG_W-1:0] dir_tags
);

    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    logic             s_own;
    logic             s_line_hit;

    // Decode the observed snoop against the directory contents
    always_comb begin
        s_idx      = snp_addr[OFF_W +: IDX_W];
        s_tag      = snp_addr[ADDR_W-1 -: TAG_W];
        s_own      = (snp_id == ID_W'(CACHE_ID));
        s_line_hit = snp_wr && !s_own && dir_valid[s_idx]
                     && (dir_tags[s_idx*TAG_W +: TAG_W] == s_tag);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !cpu_done && dir_valid == '0));

    assert_snoop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_line_hit |=> !dir_valid[$past(s_idx)]);

    assert_own_snoop_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_wr && s_own && dir_valid[s_idx]) |=> dir_valid[$past(s_idx)]);

    assert_kill_beats_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && s_line_hit
         && s_idx == cpu_addr[OFF_W +: IDX_W]) |=> !cpu_done);

    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd)
                                   && $stable(bus_addr) && $stable(bus_wdata)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

endmodule

bind snoop_wt_cache snoop_wt_cache_chk #(
    .ADDR_W   (ADDR_W),
    .LINES    (LINES),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .OFF_W    (OFF_W),
    .ID_W     (ID_W),
    .CACHE_ID (CACHE_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .cpu_addr  (cpu_addr),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .snp_wr    (snp_wr),
    .snp_addr  (snp_addr),
    .snp_id    (snp_id),
    .dir_valid (dir_valid),
    .dir_tags  (dir_tags)
);

// File: tb/sim_snoop_wt_cache.sv
// Bench for snoop_wt_cache: it acts as arbiter, memory and the other bus
// masters, and keeps its own image of memory and of which lines are held.
module sim_snoop_wt_cache;

    localparam int AW = 10;
    localparam logic [1:0] OWN_ID = 2'd0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_alloc = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [7:0]  cpu_rdata;
    logic        bus_req, bus_cmd;
    logic        bus_gnt = 1'b0;
    logic [9:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        snp_wr = 1'b0;
    logic [9:0]  snp_addr = '0;
    logic [1:0]  snp_id = '0;

    logic [7:0]  mem [1024];
    logic        m_valid [8];
    logic [3:0]  m_tag [8];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          ended = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    snoop_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .wr_alloc(wr_alloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_wr(snp_wr), .snp_addr(snp_addr), .snp_id(snp_id)
    );

    function automatic logic [2:0] idx_of(input logic [9:0] a);
        return a[5:3];
    endfunction

    function automatic logic [3:0] tag_of(input logic [9:0] a);
        return a[9:6];
    endfunction

    function automatic logic [63:0] line_of(input logic [9:0] a);
        logic [63:0] l;
        for (int b = 0; b < 8; b++) l[b*8 +: 8] = mem[{a[9:3], 3'(b)}];
        return l;
    endfunction

    function automatic bit model_hit(input logic [9:0] a);
        return m_valid[idx_of(a)] && m_tag[idx_of(a)] == tag_of(a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply a snooped write to the bench model (foreign writes change memory)
    task automatic model_snoop(input logic [9:0] a, input logic [1:0] id);
        if (id != OWN_ID) begin
            if (model_hit(a)) m_valid[idx_of(a)] = 1'b0;
            mem[a] = 8'($urandom);
        end
    endtask

    // One observed bus write from another master, on its own cycle
    task automatic snoop_only(input logic [9:0] a, input logic [1:0] id);
        snp_wr = 1'b1; snp_addr = a; snp_id = id;
        model_snoop(a, id);
        @(negedge clk);
        snp_wr = 1'b0;
    endtask

    // One processor access, with an optional snoop in the same cycle
    task automatic access(input bit we, input logic [9:0] a, input logic [7:0] wd,
                          input bit with_snp, input logic [9:0] sa, input logic [1:0] sid);
        bit exp_hit;
        int n_rd;
        int n_wr;
        int cyc;
        n_rd = 0; n_wr = 0; cyc = 0;
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (with_snp) begin
            snp_wr = 1'b1; snp_addr = sa; snp_id = sid;
            model_snoop(sa, sid);
        end
        exp_hit = model_hit(a);
        @(negedge clk);
        cpu_req = 1'b0; snp_wr = 1'b0;
        forever begin
            if (bus_gnt) begin
                bus_gnt = 1'b0; snp_wr = 1'b0;
            end
            if (cpu_done) break;
            if (cyc > 60) begin
                check(1'b0, "R12 access hang", cyc, 0);
                break;
            end
            if (bus_req && ($urandom % 3 != 0)) begin
                bus_gnt = 1'b1;
                if (bus_cmd) begin
                    n_wr++;
                    check(bus_addr == a, "R4 write addr", int'(bus_addr), int'(a));
                    check(bus_wdata == wd, "R4 write byte", int'(bus_wdata), int'(wd));
                    mem[bus_addr] = bus_wdata;
                    snp_wr = 1'b1; snp_addr = bus_addr; snp_id = OWN_ID;  // own echo
                end else begin
                    n_rd++;
                    check(bus_addr[9:3] == a[9:3], "R3 read addr", int'(bus_addr), int'(a));
                    bus_rdata = line_of(bus_addr);
                end
            end
            cyc++;
            @(negedge clk);
        end
        if (!we) begin
            check(cpu_rdata == mem[a], exp_hit ? "R2 hit data" : "R3 fill data",
                  int'(cpu_rdata), int'(mem[a]));
            check(n_rd == (exp_hit ? 0 : 1), exp_hit ? "R2 no bus read" : "R3 one line read",
                  n_rd, exp_hit ? 0 : 1);
            if (!exp_hit) begin m_valid[idx_of(a)] = 1'b1; m_tag[idx_of(a)] = tag_of(a); end
        end else begin
            check(n_wr == 1, "R4 one bus write", n_wr, 1);
            check(n_rd == ((!exp_hit && wr_alloc) ? 1 : 0),
                  exp_hit ? "R5 hit no read" : (wr_alloc ? "R7 fetch first" : "R6 no fetch"),
                  n_rd, (!exp_hit && wr_alloc) ? 1 : 0);
            if (!exp_hit && wr_alloc) begin
                m_valid[idx_of(a)] = 1'b1; m_tag[idx_of(a)] = tag_of(a);
            end
        end
        @(negedge clk);
        check(!cpu_done, "R12 done pulse", int'(cpu_done), 0);
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 8; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        check(!bus_req && !cpu_done, "R1 outputs in reset", int'({bus_req, cpu_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready && !bus_req && !cpu_done, "R1 idle after reset",
              int'({cpu_ready, bus_req, cpu_done}), 4);

        // R3 then R2: miss fills, neighbour byte hits
        access(1'b0, 10'h0A8, 8'h00, 1'b0, '0, '0);
        access(1'b0, 10'h0AB, 8'h00, 1'b0, '0, '0);
        // R4/R5: write hit, then read back without bus read
        access(1'b1, 10'h0A9, 8'h5C, 1'b0, '0, '0);
        access(1'b0, 10'h0A9, 8'h00, 1'b0, '0, '0);
        // R6: direct write miss does not allocate
        wr_alloc = 1'b0;
        access(1'b1, 10'h100, 8'hE1, 1'b0, '0, '0);
        access(1'b0, 10'h100, 8'h00, 1'b0, '0, '0);
        // R7: fetch-on-write allocates and merges
        wr_alloc = 1'b1;
        access(1'b1, 10'h204, 8'h3D, 1'b0, '0, '0);
        access(1'b0, 10'h204, 8'h00, 1'b0, '0, '0);
        access(1'b0, 10'h205, 8'h00, 1'b0, '0, '0);
        // R8: foreign snoop invalidates; reread sees new memory data
        snoop_only(10'h0AA, 2'd1);
        access(1'b0, 10'h0AA, 8'h00, 1'b0, '0, '0);
        // R8: same index, other tag leaves the line
        snoop_only(10'h006, 2'd2);
        access(1'b0, 10'h206, 8'h00, 1'b0, '0, '0);
        // R9: own-identifier snoop leaves the line
        snoop_only(10'h203, OWN_ID);
        access(1'b0, 10'h203, 8'h00, 1'b0, '0, '0);
        // R10: same-cycle kill turns a hit into a miss
        access(1'b0, 10'h206, 8'h00, 1'b1, 10'h201, 2'd3);
        access(1'b1, 10'h0AC, 8'h77, 1'b1, 10'h0AD, 2'd1);

        // Random mix over a small address pool to get hits and conflicts
        for (int k = 0; k < 400; k++) begin
            logic [9:0] ra;
            logic [9:0] sa;
            ra = 10'($urandom % 160);
            sa = 10'($urandom % 160);
            if ($urandom % 8 == 0) wr_alloc = 1'($urandom);
            if ($urandom % 4 == 0) snoop_only(sa, 2'($urandom));
            access(1'($urandom % 3 == 0), ra, 8'($urandom),
                   ($urandom % 6 == 0), sa, 2'($urandom));
        end

        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule